// File: doc/BRIEF.md
# Dual-Port Mailbox Register Block

This block is a small register file shared by two agents: a host processor and a management controller. Each agent reaches it through its own byte-wide register port. A port has an address, a write strobe, write data and registered read data. The ports carry no valid/ready handshake. A write with the strobe high always takes effect in that cycle. A read always returns data one cycle after its address is presented, so neither side can apply back-pressure.

Sixteen message bytes form the common payload area, and either side can write and read them. Two of these bytes also act as doorbells. When the controller writes the response byte, a response flag is raised. When it writes the attention byte, an attention flag is raised. The host clears these flags by writing ones. Each side has its own control register. Its ping bit raises a pending bit in the other side's control register, and its mask bit blocks the pending bit from reaching its own interrupt. Each side also has two interrupt-enable registers, one for each status register. Each agent gets one level interrupt output.

Top module: `dual_mailbox`

## Requirements
- R1: After reset, every message byte and every status, control and enable register reads 0x00, and both interrupt outputs are low.
- R2: Message bytes 0x00..0x0F can be written by either side and read by both sides. If both sides write the same byte in the same cycle, the controller's value is kept.
- R3: A controller write to byte 0x0D sets bit 5 (response) of status register 1 at 0x11. A controller write to byte 0x0F sets bit 7 (attention). Byte 0x0F still stores the written value, so the host can read back the reason code.
- R4: Status register 1 is write-one-to-clear from the host: each 1 clears its bit and each 0 leaves its bit as is. Controller writes to 0x11 have no effect.
- R5: If a flag-setting write and a host clear of the same flag happen in the same cycle, the flag ends set.
- R6: Status register 0 at 0x10 holds the last value written by the controller. Host writes to it have no effect.
- R7: The host interrupt is the OR of two terms. The first is (status0 & enable 0x16) | (status1 & enable 0x17). The second is the host pending bit gated by the host mask bit. Only the host can write 0x16 and 0x17.
- R8: The host control register is at 0x13 and the controller control register is at 0x12. In both, bit 0 is ping, bit 1 is mask and bit 7 is pending. A host write to 0x13 with bit 0 set sets the pending bit of 0x12. The controller interrupt follows that pending bit unless the mask in 0x12 is set. A controller write to 0x12 with bit 7 set clears the pending bit. Ping is not stored and reads as 0.
- R9: In the mirror direction, a controller write to 0x12 with bit 0 set sets the host pending bit at 0x13. The host clears it by writing bit 7, and the host mask in 0x13 gates it.
- R10: The controller interrupt also ORs in (status0 & enable 0x14) | (status1 & enable 0x15). Only the controller can write 0x14 and 0x15.
- R11: Addresses 0x18..0x1F read as 0x00 and ignore writes.
- R12: Read data shows the addressed register in the cycle after the address is presented, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after address |
| host_irq | output | 1 | Level interrupt to host |
| mc_we | input | 1 | Controller write strobe |
| mc_addr | input | 5 | Controller register address |
| mc_wdata | input | 8 | Controller write data |
| mc_rdata | output | 8 | Controller read data, one cycle after address |
| mc_irq | output | 1 | Level interrupt to controller |

## Verification
The bench targets the cases where both sides act on the same cycle.

- A simultaneous set and clear of the response flag. A design that let the clear win would lose a doorbell.
- A simultaneous write of the same message byte from both sides. A design with the wrong priority would keep the host value.
- Writes from the wrong side to status 0, status 1 and the other side's enable registers. A design that decoded these carelessly would change stored state.
- Ping and mask crossing between the two control registers in both directions. Mixing up which register holds the pending bit would fire the wrong interrupt, or fire it while masked.
- The read latency. A design that returned data combinationally would show the new register one cycle early.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MB_DW = 8;

  localparam int unsigned OFS_ST0  = 16;
  localparam int unsigned OFS_ST1  = 17;
  localparam int unsigned OFS_MCTL = 18;
  localparam int unsigned OFS_HCTL = 19;
  localparam int unsigned OFS_MEN0 = 20;
  localparam int unsigned OFS_MEN1 = 21;
  localparam int unsigned OFS_HEN0 = 22;
  localparam int unsigned OFS_HEN1 = 23;

  localparam int unsigned RESP_BYTE = 13;
  localparam int unsigned ATTN_BYTE = 15;

  localparam int unsigned ST1_RESP = 5;
  localparam int unsigned ST1_ATTN = 7;
  localparam int unsigned CTL_PING = 0;
  localparam int unsigned CTL_MASK = 1;
  localparam int unsigned CTL_PEND = 7;

  typedef struct packed {
    logic [MB_DW-1:0] st0;
    logic [MB_DW-1:0] st1;
    logic             h_pend;
    logic             h_mask;
    logic             m_pend;
    logic             m_mask;
    logic [MB_DW-1:0] men0;
    logic [MB_DW-1:0] men1;
    logic [MB_DW-1:0] hen0;
    logic [MB_DW-1:0] hen1;
  } mbox_regs_t;
endpackage

// File: rtl/mbox_msg_bank.sv
module mbox_msg_bank
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned MSG_BYTES = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             h_we,
  input  logic [ADDR_W-1:0]                h_addr,
  input  logic [MB_DW-1:0]                 h_wdata,
  input  logic                             m_we,
  input  logic [ADDR_W-1:0]                m_addr,
  input  logic [MB_DW-1:0]                 m_wdata,
  output logic [MSG_BYTES-1:0][MB_DW-1:0]  msg
);
  for (genvar i = 0; i < MSG_BYTES; i++) begin : g_byte
    logic h_hit, m_hit;
    assign h_hit = h_we && (h_addr == ADDR_W'(i));
    assign m_hit = m_we && (m_addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)     msg[i] <= '0;
      else if (m_hit) msg[i] <= m_wdata;
      else if (h_hit) msg[i] <= h_wdata;
    end

    // R2: controller value wins on a same-cycle collision
    a_r2_mc_wins: assert property (@(posedge clk) disable iff (!rst_n)
      m_hit |=> msg[i] == $past(m_wdata));
  end
endmodule

// File: rtl/mbox_ctl_regs.sv
module mbox_ctl_regs
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [MB_DW-1:0]  h_wdata,
  input  logic              m_we,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [MB_DW-1:0]  m_wdata,
  output mbox_regs_t        regs
);
  logic h_st1, h_hctl, h_hen0, h_hen1;
  logic m_st0, m_mctl, m_men0, m_men1, m_resp, m_attn;
  logic [MB_DW-1:0] st1_set, st1_clr;

  assign h_st1  = h_we && (h_addr == ADDR_W'(OFS_ST1));
  assign h_hctl = h_we && (h_addr == ADDR_W'(OFS_HCTL));
  assign h_hen0 = h_we && (h_addr == ADDR_W'(OFS_HEN0));
  assign h_hen1 = h_we && (h_addr == ADDR_W'(OFS_HEN1));
  assign m_st0  = m_we && (m_addr == ADDR_W'(OFS_ST0));
  assign m_mctl = m_we && (m_addr == ADDR_W'(OFS_MCTL));
  assign m_men0 = m_we && (m_addr == ADDR_W'(OFS_MEN0));
  assign m_men1 = m_we && (m_addr == ADDR_W'(OFS_MEN1));
  assign m_resp = m_we && (m_addr == ADDR_W'(RESP_BYTE));
  assign m_attn = m_we && (m_addr == ADDR_W'(ATTN_BYTE));

  always_comb begin
    st1_set = '0;
    st1_set[ST1_RESP] = m_resp;
    st1_set[ST1_ATTN] = m_attn;
    st1_clr = h_st1 ? h_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      regs.st1 <= (regs.st1 & ~st1_clr) | st1_set;
      if (m_st0)  regs.st0  <= m_wdata;
      if (h_hen0) regs.hen0 <= h_wdata;
      if (h_hen1) regs.hen1 <= h_wdata;
      if (m_men0) regs.men0 <= m_wdata;
      if (m_men1) regs.men1 <= m_wdata;
      if (h_hctl) regs.h_mask <= h_wdata[CTL_MASK];
      if (m_mctl) regs.m_mask <= m_wdata[CTL_MASK];
      regs.m_pend <= (h_hctl && h_wdata[CTL_PING]) ||
                     (regs.m_pend && !(m_mctl && m_wdata[CTL_PEND]));
      regs.h_pend <= (m_mctl && m_wdata[CTL_PING]) ||
                     (regs.h_pend && !(h_hctl && h_wdata[CTL_PEND]));
    end
  end

  a_r3_resp_set: assert property (@(posedge clk) disable iff (!rst_n)
    m_resp |=> regs.st1[ST1_RESP]);
  a_r3_attn_set: assert property (@(posedge clk) disable iff (!rst_n)
    m_attn |=> regs.st1[ST1_ATTN]);
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (h_st1 && h_wdata[ST1_RESP] && !m_resp) |=> !regs.st1[ST1_RESP]);
  a_r6_st0_host_blind: assert property (@(posedge clk) disable iff (!rst_n)
    !m_st0 |=> $stable(regs.st0));
  a_r8_ping_to_mc: assert property (@(posedge clk) disable iff (!rst_n)
    (h_hctl && h_wdata[CTL_PING]) |=> regs.m_pend);
  a_r9_ping_to_host: assert property (@(posedge clk) disable iff (!rst_n)
    (m_mctl && m_wdata[CTL_PING]) |=> regs.h_pend);
endmodule

// File: rtl/mbox_irq_gen.sv
module mbox_irq_gen
  import mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mbox_regs_t regs,
  output logic       host_irq,
  output logic       mc_irq
);
  assign host_irq = (|(regs.st0 & regs.hen0)) | (|(regs.st1 & regs.hen1)) |
                    (regs.h_pend & ~regs.h_mask);
  assign mc_irq   = (|(regs.st0 & regs.men0)) | (|(regs.st1 & regs.men1)) |
                    (regs.m_pend & ~regs.m_mask);

  a_r7_host_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (regs.hen0 == '0 && regs.hen1 == '0 && regs.h_mask) |-> !host_irq);
  a_r10_mc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (regs.men0 == '0 && regs.men1 == '0 && !regs.m_pend) |-> !mc_irq);
endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned MSG_BYTES = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [MSG_BYTES-1:0][MB_DW-1:0] msg,
  input  mbox_regs_t                      regs,
  output logic [MB_DW-1:0]                rdata
);
  localparam int unsigned IDX_W = $clog2(MSG_BYTES);
  localparam int unsigned TOP   = OFS_HEN1;
  logic [MB_DW-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr < ADDR_W'(MSG_BYTES)) sel = msg[addr[IDX_W-1:0]];
    else if (addr == ADDR_W'(OFS_ST0))  sel = regs.st0;
    else if (addr == ADDR_W'(OFS_ST1))  sel = regs.st1;
    else if (addr == ADDR_W'(OFS_MCTL)) sel = {regs.m_pend, 5'b0, regs.m_mask, 1'b0};
    else if (addr == ADDR_W'(OFS_HCTL)) sel = {regs.h_pend, 5'b0, regs.h_mask, 1'b0};
    else if (addr == ADDR_W'(OFS_MEN0)) sel = regs.men0;
    else if (addr == ADDR_W'(OFS_MEN1)) sel = regs.men1;
    else if (addr == ADDR_W'(OFS_HEN0)) sel = regs.hen0;
    else if (addr == ADDR_W'(OFS_HEN1)) sel = regs.hen1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= sel;
  end

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > ADDR_W'(TOP)) |=> rdata == '0);
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned MSG_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [MB_DW-1:0]  host_wdata,
  output logic [MB_DW-1:0]  host_rdata,
  output logic              host_irq,
  input  logic              mc_we,
  input  logic [ADDR_W-1:0] mc_addr,
  input  logic [MB_DW-1:0]  mc_wdata,
  output logic [MB_DW-1:0]  mc_rdata,
  output logic              mc_irq
);
  logic [MSG_BYTES-1:0][MB_DW-1:0] msg;
  mbox_regs_t regs;

  mbox_msg_bank #(.ADDR_W(ADDR_W), .MSG_BYTES(MSG_BYTES)) u_bank (
    .clk, .rst_n,
    .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata),
    .m_we(mc_we), .m_addr(mc_addr), .m_wdata(mc_wdata),
    .msg(msg));

  mbox_ctl_regs #(.ADDR_W(ADDR_W)) u_ctl (
    .clk, .rst_n,
    .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata),
    .m_we(mc_we), .m_addr(mc_addr), .m_wdata(mc_wdata),
    .regs(regs));

  mbox_irq_gen u_irq (.clk, .rst_n, .regs(regs), .host_irq(host_irq), .mc_irq(mc_irq));

  mbox_rd_port #(.ADDR_W(ADDR_W), .MSG_BYTES(MSG_BYTES)) u_rd_host (
    .clk, .rst_n, .addr(host_addr), .msg(msg), .regs(regs), .rdata(host_rdata));

  mbox_rd_port #(.ADDR_W(ADDR_W), .MSG_BYTES(MSG_BYTES)) u_rd_mc (
    .clk, .rst_n, .addr(mc_addr), .msg(msg), .regs(regs), .rdata(mc_rdata));

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (host_rdata == '0 && mc_rdata == '0));
endmodule

// File: tb/dual_mailbox_tb_top.sv
module dual_mailbox_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_we = 0, m_we = 0;
  logic [4:0] h_addr = '0, m_addr = '0;
  logic [7:0] h_wd = '0, m_wd = '0;
  logic [7:0] h_rd, m_rd;
  logic h_irq, m_irq;
  int nchk = 0, nfail = 0, cyc = 0;

  always #2 clk = ~clk;

  dual_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(h_we), .host_addr(h_addr), .host_wdata(h_wd),
    .host_rdata(h_rd), .host_irq(h_irq),
    .mc_we(m_we), .mc_addr(m_addr), .mc_wdata(m_wd),
    .mc_rdata(m_rd), .mc_irq(m_irq));

  // [18] read, [17] side (1 = controller), [16:12] addr, [11:4] data/expect, [3:0] req
  localparam int NV = 26;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0,1'b0,5'h00,8'hA5,4'd2},  // R2 host writes byte 0
    {1'b1,1'b1,5'h00,8'hA5,4'd2},
    {1'b0,1'b1,5'h03,8'h3C,4'd2},  // R2 controller writes byte 3
    {1'b1,1'b0,5'h03,8'h3C,4'd2},
    {1'b1,1'b0,5'h11,8'h00,4'd3},  // R3 no flag yet
    {1'b0,1'b1,5'h0D,8'h11,4'd3},  // R3 response byte
    {1'b1,1'b0,5'h11,8'h20,4'd3},
    {1'b0,1'b1,5'h0F,8'h42,4'd3},  // R3 attention byte
    {1'b1,1'b0,5'h11,8'hA0,4'd3},
    {1'b1,1'b0,5'h0F,8'h42,4'd3},
    {1'b0,1'b0,5'h11,8'h20,4'd4},  // R4 clear response only
    {1'b1,1'b0,5'h11,8'h80,4'd4},
    {1'b0,1'b1,5'h11,8'hFF,4'd4},  // R4 controller write ignored
    {1'b1,1'b0,5'h11,8'h80,4'd4},
    {1'b0,1'b0,5'h11,8'h00,4'd4},  // R4 zeros leave bits
    {1'b1,1'b0,5'h11,8'h80,4'd4},
    {1'b0,1'b0,5'h11,8'h80,4'd4},
    {1'b1,1'b1,5'h11,8'h00,4'd4},
    {1'b0,1'b1,5'h10,8'h5A,4'd6},  // R6 controller owns status 0
    {1'b1,1'b0,5'h10,8'h5A,4'd6},
    {1'b0,1'b0,5'h10,8'hFF,4'd6},  // R6 host write ignored
    {1'b1,1'b1,5'h10,8'h5A,4'd6},
    {1'b0,1'b0,5'h14,8'hFF,4'd10}, // R10 host cannot write controller enable
    {1'b1,1'b1,5'h14,8'h00,4'd10},
    {1'b0,1'b0,5'h1A,8'h77,4'd11}, // R11 unmapped
    {1'b1,1'b0,5'h1A,8'h00,4'd11}
  };

  task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic side, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    if (side) begin m_we = 1; m_addr = a; m_wd = d; end
    else      begin h_we = 1; h_addr = a; h_wd = d; end
    @(negedge clk);
    h_we = 0; m_we = 0;
  endtask

  task automatic rd(input logic side, input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    if (side) m_addr = a; else h_addr = a;
    @(negedge clk);
    v = side ? m_rd : h_rd;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(1, {7'b0, h_irq}, 8'h00);
    chk(1, {7'b0, m_irq}, 8'h00);
    rd(0, 5'h00, v); chk(1, v, 8'h00);
    rd(0, 5'h11, v); chk(1, v, 8'h00);
    rd(1, 5'h13, v); chk(1, v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] e;
      e = VEC[i];
      if (!e[18]) wr(e[17], e[16:12], e[11:4]);
      else begin
        rd(e[17], e[16:12], v);
        chk(int'(e[3:0]), v, e[11:4]);
      end
    end

    // R12 read latency: data appears only after the next edge
    rd(0, 5'h00, v); chk(12, v, 8'hA5);
    @(negedge clk); h_addr = 5'h03; #1; chk(12, h_rd, 8'hA5);
    @(negedge clk); chk(12, h_rd, 8'h3C);

    // R7 host interrupt from status 1 and status 0 enables
    wr(0, 5'h17, 8'h80);
    wr(1, 5'h0F, 8'h01);
    chk(7, {7'b0, h_irq}, 8'h01);
    wr(0, 5'h17, 8'h00); chk(7, {7'b0, h_irq}, 8'h00);
    wr(0, 5'h17, 8'h80); chk(7, {7'b0, h_irq}, 8'h01);
    wr(0, 5'h11, 8'h80); chk(7, {7'b0, h_irq}, 8'h00);
    wr(0, 5'h17, 8'h00);
    wr(0, 5'h16, 8'h01); chk(7, {7'b0, h_irq}, 8'h00); // st0=5A, bit0 clear
    wr(0, 5'h16, 8'h02); chk(7, {7'b0, h_irq}, 8'h01);
    wr(1, 5'h16, 8'h00); chk(7, {7'b0, h_irq}, 8'h01); // controller cannot write
    wr(0, 5'h16, 8'h00); chk(7, {7'b0, h_irq}, 8'h00);

    // R8 host pings controller with ping+mask
    wr(0, 5'h13, 8'h03);
    chk(8, {7'b0, m_irq}, 8'h01);
    rd(1, 5'h12, v); chk(8, v, 8'h80);
    rd(0, 5'h13, v); chk(8, v, 8'h02);
    wr(1, 5'h12, 8'h02); chk(8, {7'b0, m_irq}, 8'h00);
    rd(1, 5'h12, v); chk(8, v, 8'h82);
    wr(1, 5'h12, 8'h80);
    rd(1, 5'h12, v); chk(8, v, 8'h00);

    // R9 controller pings host; host mask still set
    wr(1, 5'h12, 8'h01);
    chk(9, {7'b0, h_irq}, 8'h00);
    rd(0, 5'h13, v); chk(9, v, 8'h82);
    wr(0, 5'h13, 8'h00); chk(9, {7'b0, h_irq}, 8'h01);
    wr(0, 5'h13, 8'h80); chk(9, {7'b0, h_irq}, 8'h00);
    chk(9, {7'b0, m_irq}, 8'h00);

    // R10 controller enables gate its interrupt
    wr(1, 5'h15, 8'h20);
    wr(1, 5'h0D, 8'h00);
    chk(10, {7'b0, m_irq}, 8'h01);
    wr(0, 5'h11, 8'h20); chk(10, {7'b0, m_irq}, 8'h00);

    // R5 set beats a same-cycle clear
    @(negedge clk);
    m_we = 1; m_addr = 5'h0D; m_wd = 8'h09;
    h_we = 1; h_addr = 5'h11; h_wd = 8'h20;
    @(negedge clk); h_we = 0; m_we = 0;
    chk(5, {7'b0, m_irq}, 8'h01);
    rd(0, 5'h11, v); chk(5, v, 8'h20);

    // R2 both sides write one byte in the same cycle
    @(negedge clk);
    m_we = 1; m_addr = 5'h05; m_wd = 8'hC3;
    h_we = 1; h_addr = 5'h05; h_wd = 8'h3C;
    @(negedge clk); h_we = 0; m_we = 0;
    rd(0, 5'h05, v); chk(2, v, 8'hC3);

    // R1 reset clears state written above
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    chk(1, {6'b0, h_irq, m_irq}, 8'h00);
    rd(0, 5'h05, v); chk(1, v, 8'h00);
    rd(1, 5'h15, v); chk(1, v, 8'h00);

    finish_run();
  end
endmodule